// File: doc/BRIEF.md
# Wake Event Indicator Generator

This block turns wake-up sources into two outputs: a host interrupt request and an external wake indication pin. Two receive-side flags, one for a matched wake-up frame and one for a magic packet, each pass through their own enable. They are then held in sticky wake status bits. A global wake-on-LAN enable qualifies those bits. An energy-detect interrupt from the PHY, qualified by its own enable, joins them to form one internal wake condition.

The wake condition sets a sticky interrupt status bit. Software clears that bit by writing a one to it, but only after the condition has gone away. The bit, qualified by an interrupt enable, drives the host IRQ whatever the state of the pin. The same condition drives the pin. In level mode the pin stays asserted while the condition holds. In pulse mode it is asserted for a fixed time of 50 ms by default, timed from a clock-frequency parameter. Polarity and drive style (open-drain or push-pull) can be selected. Register writes reach the block as plain strobes with a mask.

Top module: `wake_ind_gen`

## Requirements
- R1: Wake status bit 0 (frame) is set the cycle after `wuf_rx_i` is high with `wuf_en_i` high. Bit 1 (magic) is set likewise from `mpkt_rx_i` with `mpkt_en_i`. A flag whose enable is low leaves its bit unchanged.
- R2: A wake status bit stays set until a cycle in which `wsts_clr_we_i` is high and the matching bit of `wsts_clr_mask_i` is 1. If a set and a clear land in the same cycle, the set wins.
- R3: The internal wake condition is true when (`wol_en_i` and any wake status bit) or (`ed_en_i` and `phy_ed_i`). It is registered one cycle after those inputs.
- R4: `int_sts_o` is set one cycle after the registered wake condition is true. It stays set while that condition holds, even if `int_clr_we_i` is pulsed. Once the condition is false, an `int_clr_we_i` pulse clears it on the next cycle.
- R5: `irq_o` equals the previous cycle's `int_sts_o` AND `irq_en_i`. It is unaffected by `pin_en_i` and by the pin state.
- R6: With `pin_pulse_i` = 0 and `pin_en_i` = 1, the pin is active from one cycle after the registered wake condition rises until one cycle after it falls.
- R7: With `pin_pulse_i` = 1, a rising edge of the wake condition makes the pin active for exactly PULSE_CYC = CLK_HZ/1000*PULSE_MS cycles. A condition held for longer than that yields a single pulse.
- R8: In pulse mode, if the wake condition falls and then rises again during a pulse, a fresh full-length pulse of PULSE_CYC cycles starts.
- R9: The pin goes inactive one cycle after the wake condition is removed (by clearing the status bits or an enable), or after `pin_en_i` goes low.
- R10: With `pin_pol_i` = 1, `pin_data_o` is 1 when the pin is active. With `pin_pol_i` = 0, `pin_data_o` is 0 when active and 1 when inactive.
- R11: With `pin_pp_i` = 0 (open-drain), `pin_oe_o` is 1 only while the pin is active. With `pin_pp_i` = 1 (push-pull), `pin_oe_o` is 1 on every cycle after reset.
- R12: While `rst` is high, all status bits, `irq_o`, `pin_data_o` and `pin_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wuf_rx_i | input | 1 | Wake-up frame received flag |
| mpkt_rx_i | input | 1 | Magic packet received flag |
| phy_ed_i | input | 1 | PHY energy-detect interrupt (level) |
| wuf_en_i | input | 1 | Wake-up frame enable |
| mpkt_en_i | input | 1 | Magic packet enable |
| wol_en_i | input | 1 | Wake-on-LAN enable (gates both status bits) |
| ed_en_i | input | 1 | Energy-detect wake enable |
| wsts_clr_we_i | input | 1 | Write strobe that clears wake status bits |
| wsts_clr_mask_i | input | 2 | Wake status bits to clear (bit 0 frame, bit 1 magic) |
| int_clr_we_i | input | 1 | Write-1-to-clear strobe for the interrupt status bit |
| irq_en_i | input | 1 | Host interrupt enable |
| pin_en_i | input | 1 | Wake pin enable |
| pin_pulse_i | input | 1 | Pin mode: 1 pulse, 0 level |
| pin_pol_i | input | 1 | Pin polarity: 1 active-high, 0 active-low |
| pin_pp_i | input | 1 | Drive type: 1 push-pull, 0 open-drain |
| wake_sts_o | output | 2 | Sticky wake status bits (bit 0 frame, bit 1 magic) |
| int_sts_o | output | 1 | Sticky wake interrupt status |
| irq_o | output | 1 | Host interrupt request |
| pin_data_o | output | 1 | Wake pin data value |
| pin_oe_o | output | 1 | Wake pin output enable |

## Verification
A receive flag shows in `wake_sts_o` one cycle later. From that flag, `int_sts_o` and the pin outputs follow three cycles later and `irq_o` four cycles later. The energy-detect path skips the status stage, so each of its results is due one cycle earlier. The bench drives inputs on the falling edge. At every rising edge it advances a behavioural model through these stages, and it compares all outputs at each falling edge, so every result is checked in the exact cycle it is due. Directed checks are placed by these counts: they wait enough cycles for the slowest stage, then count the cycles in which the pin is active to measure pulse length and restart.

// File: rtl/wake_ind_pkg.sv
package wake_ind_pkg;
  localparam int NSRC = 2;

  typedef enum logic [0:0] {
    SRC_FRAME = 1'b0,
    SRC_MAGIC = 1'b1
  } wake_src_e;

  typedef enum logic {
    DRV_OPEN_DRAIN = 1'b0,
    DRV_PUSH_PULL  = 1'b1
  } drv_e;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_PULSE = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/wake_src_latch.sv
module wake_src_latch
  import wake_ind_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rx_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic         wol_en_i,
  input  logic         ed_en_i,
  input  logic         phy_ed_i,
  output logic [N-1:0] sts_o,
  output logic         cond_o,
  output logic         rise_o
);
  logic [N-1:0] sts_q;
  logic         cond_q;
  logic         wake_now;

  for (genvar g = 0; g < N; g++) begin : g_sts
    always_ff @(posedge clk) begin
      if (rst) sts_q[g] <= 1'b0;
      else     sts_q[g] <= (rx_i[g] & en_i[g]) |
                           (sts_q[g] & ~(clr_we_i & clr_mask_i[g]));
    end
  end

  always_comb begin
    wake_now = (wol_en_i & (|sts_q)) | (ed_en_i & phy_ed_i);
  end

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= wake_now;
  end

  assign sts_o  = sts_q;
  assign cond_o = cond_q;
  assign rise_o = wake_now & ~cond_q;
endmodule

// File: rtl/wake_int_status.sv
module wake_int_status (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  input  logic clr_we_i,
  input  logic irq_en_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= cond_i | (sts_q & ~clr_we_i);
      irq_q <= sts_q & irq_en_i;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/wake_pin_drive.sv
module wake_pin_drive
  import wake_ind_pkg::*;
#(
  parameter int PULSE_CYC = 1000,
  parameter int CW        = $clog2(PULSE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond_i,
  input  logic          rise_i,
  input  logic          pin_en_i,
  input  pin_mode_e     mode_i,
  input  logic          pol_i,
  input  drv_e          drv_i,
  output logic [CW-1:0] cnt_o,
  output logic          act_o,
  output logic          data_o,
  output logic          oe_o
);
  logic [CW-1:0] cnt_q;
  logic          act_now;
  logic          act_q, data_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (rise_i)         cnt_q <= CW'(PULSE_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    act_now = pin_en_i & cond_i;
    if (mode_i == MODE_PULSE) act_now = act_now & (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      data_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      act_q  <= act_now;
      data_q <= pol_i ? act_now : ~act_now;
      oe_q   <= (drv_i == DRV_PUSH_PULL) ? 1'b1 : act_now;
    end
  end

  assign cnt_o  = cnt_q;
  assign act_o  = act_q;
  assign data_o = data_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/wake_ind_gen.sv
module wake_ind_gen
  import wake_ind_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PULSE_MS = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wuf_rx_i,
  input  logic       mpkt_rx_i,
  input  logic       phy_ed_i,
  input  logic       wuf_en_i,
  input  logic       mpkt_en_i,
  input  logic       wol_en_i,
  input  logic       ed_en_i,
  input  logic       wsts_clr_we_i,
  input  logic [1:0] wsts_clr_mask_i,
  input  logic       int_clr_we_i,
  input  logic       irq_en_i,
  input  logic       pin_en_i,
  input  logic       pin_pulse_i,
  input  logic       pin_pol_i,
  input  logic       pin_pp_i,
  output logic [1:0] wake_sts_o,
  output logic       int_sts_o,
  output logic       irq_o,
  output logic       pin_data_o,
  output logic       pin_oe_o
);
  localparam int PULSE_CYC = CLK_HZ / 1000 * PULSE_MS;
  localparam int CW        = $clog2(PULSE_CYC + 1);

  logic [NSRC-1:0] rx_vec, en_vec;
  logic            cond_q, rise;
  logic [CW-1:0]   pulse_cnt;
  logic            pin_act;

  assign rx_vec[SRC_FRAME] = wuf_rx_i;
  assign rx_vec[SRC_MAGIC] = mpkt_rx_i;
  assign en_vec[SRC_FRAME] = wuf_en_i;
  assign en_vec[SRC_MAGIC] = mpkt_en_i;

  wake_src_latch #(.N(NSRC)) u_src (
    .clk        (clk),
    .rst        (rst),
    .rx_i       (rx_vec),
    .en_i       (en_vec),
    .clr_we_i   (wsts_clr_we_i),
    .clr_mask_i (wsts_clr_mask_i),
    .wol_en_i   (wol_en_i),
    .ed_en_i    (ed_en_i),
    .phy_ed_i   (phy_ed_i),
    .sts_o      (wake_sts_o),
    .cond_o     (cond_q),
    .rise_o     (rise)
  );

  wake_int_status u_int (
    .clk      (clk),
    .rst      (rst),
    .cond_i   (cond_q),
    .clr_we_i (int_clr_we_i),
    .irq_en_i (irq_en_i),
    .sts_o    (int_sts_o),
    .irq_o    (irq_o)
  );

  wake_pin_drive #(.PULSE_CYC(PULSE_CYC), .CW(CW)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .cond_i   (cond_q),
    .rise_i   (rise),
    .pin_en_i (pin_en_i),
    .mode_i   (pin_mode_e'(pin_pulse_i)),
    .pol_i    (pin_pol_i),
    .drv_i    (drv_e'(pin_pp_i)),
    .cnt_o    (pulse_cnt),
    .act_o    (pin_act),
    .data_o   (pin_data_o),
    .oe_o     (pin_oe_o)
  );
endmodule

// File: rtl/wake_ind_gen_chk.sv
module wake_ind_gen_chk #(
  parameter int PULSE_CYC = 1000,
  parameter int CW        = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    wake_sts_o,
  input logic          wsts_clr_we_i,
  input logic [1:0]    wsts_clr_mask_i,
  input logic          int_clr_we_i,
  input logic          int_sts_o,
  input logic          irq_o,
  input logic          irq_en_i,
  input logic          pin_en_i,
  input logic          pin_pol_i,
  input logic          pin_pp_i,
  input logic          pin_data_o,
  input logic          pin_oe_o,
  input logic          cond_q,
  input logic [CW-1:0] pulse_cnt,
  input logic          pin_act
);
  p_sts0_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_sts_o[0]) |-> $past(wsts_clr_we_i && wsts_clr_mask_i[0]));
  p_sts1_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_sts_o[1]) |-> $past(wsts_clr_we_i && wsts_clr_mask_i[1]));
  p_int_set_r4: assert property (@(posedge clk) disable iff (rst)
    cond_q |=> int_sts_o);
  p_int_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(int_sts_o) |-> $past(int_clr_we_i));
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(int_sts_o && irq_en_i));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= CW'(PULSE_CYC));
  p_pin_off_r9: assert property (@(posedge clk) disable iff (rst)
    !pin_en_i |=> !pin_act);
  p_pol_r10: assert property (@(posedge clk) disable iff (rst)
    pin_pol_i |=> (pin_data_o == pin_act));
  p_od_oe_r11: assert property (@(posedge clk) disable iff (rst)
    !pin_pp_i |=> (pin_oe_o == pin_act));
  p_pp_oe_r11: assert property (@(posedge clk) disable iff (rst)
    pin_pp_i |=> pin_oe_o);
endmodule

bind wake_ind_gen wake_ind_gen_chk #(.PULSE_CYC(PULSE_CYC), .CW(CW)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .wake_sts_o      (wake_sts_o),
  .wsts_clr_we_i   (wsts_clr_we_i),
  .wsts_clr_mask_i (wsts_clr_mask_i),
  .int_clr_we_i    (int_clr_we_i),
  .int_sts_o       (int_sts_o),
  .irq_o           (irq_o),
  .irq_en_i        (irq_en_i),
  .pin_en_i        (pin_en_i),
  .pin_pol_i       (pin_pol_i),
  .pin_pp_i        (pin_pp_i),
  .pin_data_o      (pin_data_o),
  .pin_oe_o        (pin_oe_o),
  .cond_q          (cond_q),
  .pulse_cnt       (pulse_cnt),
  .pin_act         (pin_act)
);

// File: tb/wake_ind_gen_tb.sv
`timescale 1ns/1ps
module wake_ind_gen_tb_top;
  localparam int CLK_HZ   = 20_000;
  localparam int PULSE_MS = 50;
  localparam int P        = CLK_HZ / 1000 * PULSE_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wuf_rx = 0, mpkt_rx = 0, phy_ed = 0;
  logic wuf_en = 0, mpkt_en = 0, wol_en = 0, ed_en = 0;
  logic wclr = 0;
  logic [1:0] wmask = 2'b00;
  logic iclr = 0, irq_en = 0;
  logic pin_en = 0, pin_pulse = 0, pin_pol = 1, pin_pp = 0;
  logic [1:0] wake_sts;
  logic int_sts, irq, pin_data, pin_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  wake_ind_gen #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) dut_i (
    .clk(clk), .rst(rst),
    .wuf_rx_i(wuf_rx), .mpkt_rx_i(mpkt_rx), .phy_ed_i(phy_ed),
    .wuf_en_i(wuf_en), .mpkt_en_i(mpkt_en), .wol_en_i(wol_en), .ed_en_i(ed_en),
    .wsts_clr_we_i(wclr), .wsts_clr_mask_i(wmask), .int_clr_we_i(iclr),
    .irq_en_i(irq_en), .pin_en_i(pin_en), .pin_pulse_i(pin_pulse),
    .pin_pol_i(pin_pol), .pin_pp_i(pin_pp),
    .wake_sts_o(wake_sts), .int_sts_o(int_sts), .irq_o(irq),
    .pin_data_o(pin_data), .pin_oe_o(pin_oe)
  );

  // behavioural reference model
  bit m_sts[2];
  bit m_cond, m_int, m_irq, m_data, m_oe;
  int m_left;
  bit model_on = 1'b1;

  always @(posedge clk) begin
    bit wake, on, clr0, clr1;
    if (rst) begin
      m_sts[0] = 0; m_sts[1] = 0; m_cond = 0; m_int = 0; m_irq = 0;
      m_left = 0; m_data = 0; m_oe = 0;
    end else begin
      wake = (wol_en && (m_sts[0] || m_sts[1])) || (ed_en && phy_ed);
      on   = pin_en && m_cond && (!pin_pulse || m_left > 0);
      m_data = pin_pol ? on : !on;
      m_oe   = pin_pp ? 1'b1 : on;
      m_irq  = m_int && irq_en;
      m_int  = m_cond || (m_int && !iclr);
      if (wake && !m_cond) m_left = P;
      else if (m_left > 0) m_left = m_left - 1;
      m_cond = wake;
      clr0 = wclr && wmask[0];
      clr1 = wclr && wmask[1];
      m_sts[0] = (wuf_rx && wuf_en) || (m_sts[0] && !clr0);
      m_sts[1] = (mpkt_rx && mpkt_en) || (m_sts[1] && !clr1);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check("R1/R2 wake_sts", int'(wake_sts), int'({m_sts[1], m_sts[0]}));
      check("R4 int_sts", int'(int_sts), int'(m_int));
      check("R5 irq", int'(irq), int'(m_irq));
      check("R10 pin_data", int'(pin_data), int'(m_data));
      check("R11 pin_oe", int'(pin_oe), int'(m_oe));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wuf();
    wuf_rx = 1; tick(1); wuf_rx = 0;
  endtask

  task automatic pulse_mpkt();
    mpkt_rx = 1; tick(1); mpkt_rx = 0;
  endtask

  task automatic clear_wsts(input logic [1:0] m);
    wclr = 1; wmask = m; tick(1); wclr = 0; wmask = 2'b00;
  endtask

  task automatic clear_int();
    iclr = 1; tick(1); iclr = 0;
  endtask

  task automatic count_active(input int span, output int n);
    n = 0;
    for (int i = 0; i < span; i++) begin
      tick(1);
      if (pin_data == pin_pol) n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    tick(100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    tick(3);
    // R12: reset state
    check("R12 sts", int'(wake_sts), 0);
    check("R12 irq", int'(irq), 0);
    check("R12 pin", int'({pin_data, pin_oe}), 0);
    rst = 0;
    tick(2);

    // level mode, open drain, active high
    wol_en = 1; wuf_en = 1; irq_en = 1; pin_en = 1;
    pulse_wuf();
    tick(4);
    check("R1 frame bit", int'(wake_sts), 1);
    check("R4 int set", int'(int_sts), 1);
    check("R5 irq", int'(irq), 1);
    check("R6 level pin", int'(pin_data), 1);
    check("R11 od oe", int'(pin_oe), 1);

    // R1: magic flag with enable low is ignored
    pulse_mpkt();
    tick(2);
    check("R1 magic ignored", int'(wake_sts), 1);

    // R4: clear while active does nothing
    clear_int();
    tick(1);
    check("R4 clear while active", int'(int_sts), 1);

    // R2: set and clear in same cycle, set wins
    wuf_rx = 1; wclr = 1; wmask = 2'b01; tick(1);
    wuf_rx = 0; wclr = 0; wmask = 2'b00;
    check("R2 set wins", int'(wake_sts), 1);

    // R9: removing source deactivates pin; R4 then clear works
    clear_wsts(2'b01);
    tick(3);
    check("R9 pin off", int'(pin_data), 0);
    check("R4 int held", int'(int_sts), 1);
    clear_int();
    check("R4 cleared", int'(int_sts), 0);
    tick(1);
    check("R5 irq off", int'(irq), 0);

    // R3: energy detect path without wake-on-LAN
    wol_en = 0; ed_en = 1; phy_ed = 1;
    tick(3);
    check("R3 ed condition", int'(int_sts), 1);
    ed_en = 0; tick(2);
    check("R9 ed enable off", int'(pin_data), 0);
    phy_ed = 0; clear_int(); tick(2);

    // R7: pulse mode, held condition gives one pulse
    pin_pulse = 1; wol_en = 1; mpkt_en = 1;
    pulse_mpkt();
    count_active(P + 300, n);
    check("R7 pulse length", n, P);
    check("R7 cond still held", int'(int_sts), 1);

    // R8: retrigger restarts pulse
    clear_wsts(2'b10); tick(3);
    pulse_mpkt();
    tick(300);
    clear_wsts(2'b10); tick(3);
    check("R9 pulse cut", int'(pin_data), 0);
    pulse_mpkt();
    count_active(P + 300, n);
    check("R8 restart length", n, P);
    clear_wsts(2'b10); tick(3); clear_int(); tick(2);

    // R5: irq independent of pin enable
    pin_en = 0; pin_pulse = 0;
    pulse_wuf(); tick(5);
    check("R5 irq without pin", int'(irq), 1);
    check("R9 pin disabled", int'(pin_data), 0);

    // R10/R11: active low, push-pull
    pin_en = 1; pin_pol = 0; pin_pp = 1;
    tick(2);
    check("R10 active low", int'(pin_data), 0);
    check("R11 push-pull oe", int'(pin_oe), 1);
    clear_wsts(2'b01); tick(3);
    check("R10 idle high", int'(pin_data), 1);
    check("R11 pp oe idle", int'(pin_oe), 1);
    tick(5);
    model_on = 1'b0;
    finish_run();
  end
endmodule